// File: doc/BRIEF.md
# Four-channel power-of-two clock generator

The block turns one base clock into four slower timing signals: an encoder sample clock, a pulse-frequency clock, a DAC clock and an ADC clock. Each channel has its own 3-bit log2 divide setting N, so its rate is the base rate divided by 2^N. N runs from 0 to 7, which gives divide ratios from 1 to 128. The four settings are packed into one 12-bit control word. All channels are derived from one shared free-running 7-bit cycle counter, so their outputs stay phase-aligned.

Each channel gives two outputs. The first is a single-cycle enable pulse, which downstream logic uses as a clock enable. The second is a clock-shaped output, which is a registered signal and never a gated clock.

A new control word is first held in a shadow register. It becomes active only when the counter returns to zero, so reprogramming never produces a runt pulse or a doubled pulse. A select input can replace the encoder-sample channel with an external sample clock. That external input is synchronized and edge-detected first, and the other three channels are not affected.

Top module: `pwr2_clkgen`

## Requirements
- R1: While reset is asserted and just after it, rd_data reads 2258 (fields N0=2, N1=2, N2=3, N3=4) and the cycle count is zero. The first rising clock edge after release makes the count 1.
- R2: The control word packs the channel fields as follows. Channel 0 (encoder sample) is in bits [2:0], channel 1 (pulse-frequency) is in bits [5:3], channel 2 (DAC) is in bits [8:6], and channel 3 (ADC) is in bits [11:9].
- R3: For a channel with field N>0, tick is high exactly in the cycles where the low N bits of the free-running 7-bit cycle count are all ones. That is one pulse every 2^N cycles, or 128>>N pulses per 128 cycles. For N=0, tick is high in every cycle.
- R4: For N>0, clk_out equals bit N-1 of the cycle count. For N=0, clk_out is the channel's tick delayed by one register.
- R5: A write (wr_en high at a clock edge) loads only the shadow. rd_data and all outputs keep using the old word until the cycle count returns to 0. From that cycle onward, rd_data reads the new word.
- R6: With ext_sel high, tick[0] gives exactly one pulse for each rising edge of ext_sclk, after a two-flop synchronizer. clk_out[0] is the synchronized level, and field N0 is ignored: with ext_sclk held low, tick[0] stays 0.
- R7: ext_sel has no effect on channels 1 to 3.
- R8: No channel with N>0 pulses tick in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Load wr_data into the shadow register |
| wr_data | input | 12 | New packed control word |
| rd_data | output | 12 | Active control word |
| ext_sel | input | 1 | Take channel 0 from ext_sclk |
| ext_sclk | input | 1 | External sample clock, asynchronous |
| tick | output | 4 | Per-channel single-cycle enable pulses |
| clk_out | output | 4 | Per-channel clock-shaped outputs |

## Verification
The divider is tried with four control words: the reset default, all fields at zero, all fields at seven, and a word that mixes four different values. Over a full 128-cycle window, each word is compared cycle by cycle against the counter formula, and the number of pulses per channel is counted. This catches swapped fields, off-by-one masks and wrong tap bits. A write made in the middle of a counter period confirms that the change is deferred until the wrap.

The external override is tried two ways. With the external input held low, the test shows that the channel's own field no longer drives the output. With the external input toggling, the test confirms one pulse per edge, while the other channels keep their own rate.

// File: rtl/pwr2_clkgen_pkg.sv
package pwr2_clkgen_pkg;
  localparam int FIELD_W = 3;
  localparam int NUM_CH  = 4;
  localparam int WORD_W  = FIELD_W * NUM_CH;
  localparam int CNT_W   = (1 << FIELD_W) - 1;
  localparam logic [WORD_W-1:0] RESET_WORD = 12'd2258;
endpackage

// File: rtl/pwr2_divchain.sv
module pwr2_divchain #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  assign wrap = &cnt;

  // R1: after the count reads all ones, it restarts at zero
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/pwr2_cfgreg.sv
module pwr2_cfgreg #(
  parameter int                WORD_W     = 12,
  parameter logic [WORD_W-1:0] RESET_WORD = 12'd2258
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              wrap,
  output logic [WORD_W-1:0] active
);
  logic [WORD_W-1:0] shadow, shadow_d, active_d;

  always_comb begin
    shadow_d = shadow;
    if (wr_en) shadow_d = wr_data;
    active_d = active;
    if (wrap) active_d = shadow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RESET_WORD;
      active <= RESET_WORD;
    end else begin
      shadow <= shadow_d;
      active <= active_d;
    end
  end

  // R5: the active word may change only on the edge that leaves the wrap cycle
  a_r5_hold_between_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active));
endmodule

// File: rtl/pwr2_chtap.sv
module pwr2_chtap #(
  parameter int FIELD_W = 3,
  parameter int CNT_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] n,
  input  logic [CNT_W-1:0]   cnt,
  output logic               tick,
  output logic               clk_out
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0]   cnt_ext, mask;
  logic [FIELD_W-1:0] tap_idx;
  logic               tick_q;

  always_comb begin
    cnt_ext = {1'b0, cnt};
    mask    = ({{CNT_W{1'b0}}, 1'b1} << n) - 1'b1;
    tick    = ((cnt_ext & mask) == mask);
    tap_idx = n - 1'b1;
    clk_out = (n == '0) ? tick_q : cnt_ext[tap_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick;
  end

  // R8: only a divide-by-one channel may pulse in back-to-back cycles
  a_r8_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && tick_q) |-> (n == '0));
endmodule

// File: rtl/pwr2_extsync.sv
module pwr2_extsync (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_in,
  output logic level,
  output logic rise
);
  logic s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= ext_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level = s2;
  assign rise  = s2 & ~s3;

  // R6: one edge yields one pulse, never two in a row
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pwr2_clkgen.sv
module pwr2_clkgen
  import pwr2_clkgen_pkg::*;
#(
  parameter logic [WORD_W-1:0] INIT_WORD = RESET_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ext_sel,
  input  logic              ext_sclk,
  output logic [NUM_CH-1:0] tick,
  output logic [NUM_CH-1:0] clk_out
);
  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [WORD_W-1:0] active;
  logic [NUM_CH-1:0] int_tick, int_clk;
  logic              ext_level, ext_rise;

  pwr2_divchain #(.CNT_W(CNT_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .wrap(wrap));

  pwr2_cfgreg #(.WORD_W(WORD_W), .RESET_WORD(INIT_WORD)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wrap(wrap), .active(active));

  pwr2_extsync u_ext (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_sclk),
    .level(ext_level), .rise(ext_rise));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    pwr2_chtap #(.FIELD_W(FIELD_W), .CNT_W(CNT_W)) u_tap (
      .clk(clk), .rst_n(rst_n),
      .n(active[ch*FIELD_W +: FIELD_W]), .cnt(cnt),
      .tick(int_tick[ch]), .clk_out(int_clk[ch]));
  end

  always_comb begin
    tick    = int_tick;
    clk_out = int_clk;
    if (ext_sel) begin
      tick[0]    = ext_rise;
      clk_out[0] = ext_level;
    end
  end

  assign rd_data = active;

  // R7: the override never touches channels 1..3
  a_r7_upper_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    tick[NUM_CH-1:1] == int_tick[NUM_CH-1:1]);
endmodule

// File: tb/pwr2_clkgen_bench.sv
module pwr2_clkgen_bench;
  localparam time PERIOD = 10ns;

  logic        clk, rst_n, wr_en, ext_sel, ext_sclk;
  logic [11:0] wr_data, rd_data;
  logic [3:0]  tick, clk_out;
  logic [6:0]  bc;
  int n_cmp, n_bad;

  localparam logic [11:0] VW [4] = '{12'd2258, 12'h000, 12'hFFF, 12'd425};
  localparam int VC [4][4] = '{'{32, 32, 16, 8}, '{128, 128, 128, 128},
                                '{1, 1, 1, 1},    '{64, 4, 2, 128}};

  pwr2_clkgen u_pwr2_clkgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ext_sel(ext_sel), .ext_sclk(ext_sclk),
    .tick(tick), .clk_out(clk_out));

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bc <= '0;
    else        bc <= bc + 1'b1;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at bc=%0d", req, act, exp, bc);
    end
  endtask

  function automatic logic exp_tick(input logic [2:0] n, input logic [6:0] c);
    logic [7:0] m;
    m = (8'd1 << n) - 8'd1;
    return (({1'b0, c} & m) == m);
  endfunction

  function automatic logic exp_clk(input logic [2:0] n, input logic [6:0] c);
    if (n == 3'd0) return 1'b1;
    return c[n-3'd1];
  endfunction

  task automatic wait_bc(input int v);
    do @(negedge clk); while (bc != 7'(v));
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnts[4];
    int pulses;
    logic [11:0] w;
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; ext_sel = 1'b0; ext_sclk = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 2258);
    chk("R1 tick", tick, 0);
    chk("R1 clk_out", clk_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first count", tick, {3'b000, exp_tick(3'd2, 7'd1)});

    for (int v = 0; v < 4; v++) begin
      w = VW[v];
      wait_bc(10);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
      // R5 deferred until wrap
      chk("R5 old word held", rd_data, (v == 0) ? 2258 : int'(VW[v-1]));
      wait_bc(0);
      chk("R5 new word at wrap", rd_data, int'(w));
      cnts = '{0, 0, 0, 0};
      for (int c = 0; c < 128; c++) begin
        for (int ch = 0; ch < 4; ch++) begin
          // R2 field position, R3 tick, R4 clk_out
          chk($sformatf("R3 tick ch%0d", ch), tick[ch], exp_tick(w[ch*3 +: 3], bc));
          chk($sformatf("R4 clk ch%0d", ch), clk_out[ch], exp_clk(w[ch*3 +: 3], bc));
          cnts[ch] += int'(tick[ch]);
        end
        if (c != 127) @(negedge clk);
      end
      for (int ch = 0; ch < 4; ch++)
        chk($sformatf("R2 R8 count ch%0d", ch), cnts[ch], VC[v][ch]);
    end

    // word 425: N0=1 N1=5 N2=6 N3=0; override channel 0
    ext_sel = 1'b1; ext_sclk = 1'b0;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 20; c++) begin
      chk("R6 field ignored", tick[0], 0);
      for (int ch = 1; ch < 4; ch++)
        chk("R7 others unaffected", tick[ch], exp_tick(VW[3][ch*3 +: 3], bc));
      @(negedge clk);
    end
    pulses = 0;
    for (int c = 0; c < 64; c++) begin
      if (c < 60) ext_sclk = ((c % 12) < 6);
      else        ext_sclk = 1'b0;
      pulses += int'(tick[0]);
      chk("R7 others during ext", tick[3], 1);
      @(negedge clk);
    end
    repeat (4) begin pulses += int'(tick[0]); @(negedge clk); end
    chk("R6 one pulse per edge", pulses, 5);
    ext_sel = 1'b0;
    @(negedge clk);
    chk("R6 field back", tick[0], exp_tick(3'd1, bc));

    // R1 reset again restores default
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 re-reset word", rd_data, 2258);
    rst_n = 1'b1;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule